// File: doc/BRIEF.md
# 32-bit Arithmetic Logic Unit with Set-Less-Than and Zero Detect

This block is a purely combinational arithmetic logic unit for a simple processor datapath. It takes two operands and a 4-bit operation code. It returns a result word together with a zero flag and a signed-overflow flag. The datapath is a chain of identical one-bit slices with a ripple carry. The most significant position uses a dedicated slice, which also works out the signed-overflow and set signals.

Every slice can complement either operand before it reaches the gates and the full adder. A 2-bit selector then picks the AND output, the OR output, the sum, or a "less" input. The operation code is not decoded through a table. It is packed as fields:
- bit 3 inverts operand A;
- bit 2 inverts operand B and also supplies the carry into bit 0;
- bits 1:0 drive the output selector.

Subtraction therefore comes out as A plus the complement of B plus one. NOR is the AND of both complemented operands. Set-less-than sends the signed comparison result from the top slice back into the "less" input of bit 0. A branch on equality can use the zero flag after a subtraction.

Top module: `alu32_core`

## Requirements
- R1: Operation code 0000 gives `result` = A AND B.
- R2: Operation code 0001 gives `result` = A OR B.
- R3: Operation code 0010 gives `result` = (A + B) modulo 2^WIDTH.
- R4: Operation code 0110 gives `result` = (A − B) modulo 2^WIDTH, computed as A + ~B + 1.
- R5: Operation code 1100 gives `result` = NOT (A OR B).
- R6: Operation code 0111 gives `result` bit 0 = 1 when A < B as signed two's-complement numbers, and 0 otherwise. All higher bits of `result` are 0. The comparison stays correct when the internal subtraction overflows.
- R7: `zero_flag` is 1 exactly when every bit of `result` is 0. After a subtraction it is therefore 1 exactly when A equals B.
- R8: For add (0010) and subtract (0110), `ovf_flag` is 1 exactly when the signed two's-complement result cannot be represented in WIDTH bits.
- R9: Any other code acts by its fields. Bit 3 set complements A. Bit 2 set complements B and forces the bit-0 carry-in to 1. Bits 1:0 select the output: 00 = AND, 01 = OR, 10 = sum, 11 = less. Examples: 1000 gives ~A AND B, 1101 gives ~A OR ~B, 1110 gives ~A + ~B + 1, and 0100 gives A AND ~B.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opnd_a | input | WIDTH (32) | First operand |
| opnd_b | input | WIDTH (32) | Second operand |
| op_code | input | 4 | Operation code fields: invert A, invert B / carry-in, output select |
| result | output | WIDTH (32) | Selected result word |
| zero_flag | output | 1 | High when the result word is all zeros |
| ovf_flag | output | 1 | Signed overflow of the adder chain |

## Verification
The block holds no state, so a wrong internal signal shows up at the ports in the same evaluation in which the inputs change.

Each fault has a typical signature at the ports:
- A broken carry link corrupts sums and differences from that bit upward, and it affects only operand pairs whose carries pass through that bit. The random sweep is aimed at such pairs.
- A wrong feedback path into the bit-0 "less" input shows up only in set-less-than results.
- Using the raw subtraction sign instead of the sign XOR overflow goes wrong only for operand pairs of opposite sign far apart. The directed extreme-value pairs cover that case.
- A mis-wired invert control appears only in the codes that use it. This is why codes outside the listed six are also applied.

// File: rtl/alu_pkg.sv
package alu_pkg;
   localparam int OP_W = 4;

   typedef enum logic [1:0] {
      SEL_AND  = 2'b00,
      SEL_OR   = 2'b01,
      SEL_SUM  = 2'b10,
      SEL_LESS = 2'b11
   } out_sel_e;

   typedef struct packed {
      logic     inv_a;
      logic     inv_b;
      out_sel_e sel;
   } alu_ctl_t;

   localparam logic [OP_W-1:0] OP_AND = 4'b0000;
   localparam logic [OP_W-1:0] OP_OR  = 4'b0001;
   localparam logic [OP_W-1:0] OP_ADD = 4'b0010;
   localparam logic [OP_W-1:0] OP_SUB = 4'b0110;
   localparam logic [OP_W-1:0] OP_SLT = 4'b0111;
   localparam logic [OP_W-1:0] OP_NOR = 4'b1100;
endpackage

// File: rtl/alu_decode.sv
module alu_decode
   import alu_pkg::*;
(
   input  logic [OP_W-1:0] op_i,
   output alu_ctl_t        ctl_o
);
   always_comb begin
      ctl_o.inv_a = op_i[3];
      ctl_o.inv_b = op_i[2];
      ctl_o.sel   = out_sel_e'(op_i[1:0]);
   end
endmodule

// File: rtl/alu_slice.sv
module alu_slice
   import alu_pkg::*;
(
   input  logic     a_i,
   input  logic     b_i,
   input  logic     carry_i,
   input  logic     less_i,
   input  alu_ctl_t ctl_i,
   output logic     res_o,
   output logic     carry_o
);
   logic ax, bx, half, sum;

   assign ax      = a_i ^ ctl_i.inv_a;
   assign bx      = b_i ^ ctl_i.inv_b;
   assign half    = ax ^ bx;
   assign sum     = half ^ carry_i;
   assign carry_o = (ax & bx) | (half & carry_i);

   always_comb begin
      unique case (ctl_i.sel)
         SEL_AND:  res_o = ax & bx;
         SEL_OR:   res_o = ax | bx;
         SEL_SUM:  res_o = sum;
         SEL_LESS: res_o = less_i;
         default:  res_o = 1'b0;
      endcase
   end
endmodule

// File: rtl/alu_msb_slice.sv
module alu_msb_slice
   import alu_pkg::*;
(
   input  logic     a_i,
   input  logic     b_i,
   input  logic     carry_i,
   input  logic     less_i,
   input  alu_ctl_t ctl_i,
   output logic     res_o,
   output logic     carry_o,
   output logic     set_o,
   output logic     ovf_o
);
   logic ax, bx, half, sum;

   assign ax      = a_i ^ ctl_i.inv_a;
   assign bx      = b_i ^ ctl_i.inv_b;
   assign half    = ax ^ bx;
   assign sum     = half ^ carry_i;
   assign carry_o = (ax & bx) | (half & carry_i);
   assign ovf_o   = carry_i ^ carry_o;
   assign set_o   = sum ^ ovf_o;

   always_comb begin
      unique case (ctl_i.sel)
         SEL_AND:  res_o = ax & bx;
         SEL_OR:   res_o = ax | bx;
         SEL_SUM:  res_o = sum;
         SEL_LESS: res_o = less_i;
         default:  res_o = 1'b0;
      endcase
   end

   always_comb begin
      // R8
      msb_ovf_chk: assert (!ovf_o || ((ax == bx) && (sum != ax)))
         else $error("overflow flagged with operand signs %b/%b and sum %b", ax, bx, sum);
   end
endmodule

// File: rtl/alu32_core.sv
module alu32_core
   import alu_pkg::*;
#(
   parameter int WIDTH = 32
) (
   input  logic [WIDTH-1:0] opnd_a,
   input  logic [WIDTH-1:0] opnd_b,
   input  logic [3:0]       op_code,
   output logic [WIDTH-1:0] result,
   output logic             zero_flag,
   output logic             ovf_flag
);
   localparam int MSB = WIDTH - 1;

   generate
      if (WIDTH < 2) begin : g_width_bad
         $error("alu32_core: WIDTH must be at least 2");
      end
   endgenerate

   alu_ctl_t         ctl;
   logic [WIDTH:0]   carry;
   logic             set_w;

   alu_decode u_dec (
      .op_i  (op_code),
      .ctl_o (ctl)
   );

   assign carry[0] = ctl.inv_b;

   generate
      for (genvar i = 0; i < MSB; i++) begin : g_slice
         alu_slice u_bit (
            .a_i     (opnd_a[i]),
            .b_i     (opnd_b[i]),
            .carry_i (carry[i]),
            .less_i  ((i == 0) ? set_w : 1'b0),
            .ctl_i   (ctl),
            .res_o   (result[i]),
            .carry_o (carry[i+1])
         );
      end
   endgenerate

   alu_msb_slice u_msb (
      .a_i     (opnd_a[MSB]),
      .b_i     (opnd_b[MSB]),
      .carry_i (carry[MSB]),
      .less_i  (1'b0),
      .ctl_i   (ctl),
      .res_o   (result[MSB]),
      .carry_o (carry[WIDTH]),
      .set_o   (set_w),
      .ovf_o   (ovf_flag)
   );

   assign zero_flag = ~|result;

   always_comb begin
      if (op_code == OP_AND) begin
         // R1
         and_word_chk: assert (result == (opnd_a & opnd_b))
            else $error("AND word mismatch");
      end
      if (op_code == OP_ADD) begin
         // R3
         add_word_chk: assert (result == WIDTH'(opnd_a + opnd_b))
            else $error("add word mismatch");
      end
      if (op_code == OP_SUB) begin
         // R4
         sub_word_chk: assert (result == WIDTH'(opnd_a - opnd_b))
            else $error("subtract word mismatch");
         // R7
         sub_zero_chk: assert (zero_flag == (opnd_a == opnd_b))
            else $error("equality through subtraction mismatch");
      end
      if (op_code == OP_NOR) begin
         // R5
         nor_word_chk: assert (result == ~(opnd_a | opnd_b))
            else $error("NOR word mismatch");
      end
      if (op_code == OP_SLT) begin
         // R6
         slt_word_chk: assert (result == WIDTH'($signed(opnd_a) < $signed(opnd_b)))
            else $error("set-less-than mismatch");
      end
   end
endmodule

// File: tb/tb_alu32_core.sv
module tb_alu32_core;
   localparam int W = 32;

   typedef struct {
      logic [W-1:0] exp_res;
      logic         exp_ovf;
      logic         ovf_care;
      string        tag;
      logic [3:0]   op;
      logic [W-1:0] a;
      logic [W-1:0] b;
   } item_t;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic [W-1:0] a_in = '0;
   logic [W-1:0] b_in = '0;
   logic [3:0]   op_in = 4'b0000;
   logic [W-1:0] result;
   logic         zero_flag;
   logic         ovf_flag;

   int   n_vec = 0;
   int   n_bad = 0;
   bit   finished = 1'b0;
   logic [31:0] rng = 32'h1234_5678;
   item_t q[$];

   always #10 clk = ~clk;

   alu32_core #(.WIDTH(W)) dut (
      .opnd_a    (a_in),
      .opnd_b    (b_in),
      .op_code   (op_in),
      .result    (result),
      .zero_flag (zero_flag),
      .ovf_flag  (ovf_flag)
   );

   function automatic logic [31:0] next_rng(input logic [31:0] s);
      logic [31:0] x;
      x = s;
      x = x ^ (x << 13);
      x = x ^ (x >> 17);
      x = x ^ (x << 5);
      return x;
   endfunction

   task automatic drive(input logic [3:0] op, input logic [W-1:0] a,
                        input logic [W-1:0] b, input string tag);
      item_t it;
      logic [W-1:0] xa, xb;
      logic [W:0]   s;
      it.op = op; it.a = a; it.b = b; it.tag = tag;
      it.ovf_care = 1'b0;
      it.exp_ovf  = 1'b0;
      case (op)
         4'b0000: it.exp_res = a & b;
         4'b0001: it.exp_res = a | b;
         4'b0010: begin
            it.exp_res  = a + b;
            it.ovf_care = 1'b1;
            it.exp_ovf  = (a[W-1] == b[W-1]) && (it.exp_res[W-1] != a[W-1]);
         end
         4'b0110: begin
            it.exp_res  = a - b;
            it.ovf_care = 1'b1;
            it.exp_ovf  = (a[W-1] != b[W-1]) && (it.exp_res[W-1] != a[W-1]);
         end
         4'b0111: it.exp_res = ($signed(a) < $signed(b)) ? W'(1) : W'(0);
         4'b1100: it.exp_res = ~(a | b);
         default: begin
            xa = op[3] ? ~a : a;
            xb = op[2] ? ~b : b;
            s  = {1'b0, xa} + {1'b0, xb} + (W+1)'(op[2]);
            case (op[1:0])
               2'b00: it.exp_res = xa & xb;
               2'b01: it.exp_res = xa | xb;
               2'b10: it.exp_res = s[W-1:0];
               default: it.exp_res = 'x;
            endcase
         end
      endcase
      @(negedge clk);
      a_in  = a;
      b_in  = b;
      op_in = op;
      q.push_back(it);
   endtask

   always @(posedge clk) begin
      if (q.size() > 0) begin
         item_t it;
         it = q.pop_front();
         n_vec++;
         if (result !== it.exp_res) begin
            n_bad++;
            $display("FAIL %s result op=%b a=%h b=%h: got %h expected %h",
                     it.tag, it.op, it.a, it.b, result, it.exp_res);
         end
         if (zero_flag !== (it.exp_res == '0)) begin
            n_bad++;
            $display("FAIL R7 zero op=%b a=%h b=%h: got %b expected %b",
                     it.op, it.a, it.b, zero_flag, (it.exp_res == '0));
         end
         if (it.ovf_care && (ovf_flag !== it.exp_ovf)) begin
            n_bad++;
            $display("FAIL R8 overflow op=%b a=%h b=%h: got %b expected %b",
                     it.op, it.a, it.b, ovf_flag, it.exp_ovf);
         end
      end
   end

   initial begin
      #(20 * 150000);
      if (!finished) begin
         n_bad++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      rst_n = 1'b1;
      // reset state: all-zero operands give a zero word (R7)
      drive(4'b0000, '0, '0, "R7");
      // R1 and R2 directed
      drive(4'b0000, 32'hF0F0_1234, 32'h0FF0_FFFF, "R1");
      drive(4'b0001, 32'hF000_0000, 32'h0000_000F, "R2");
      // R3 directed, with carry-out and overflow corners (R8)
      drive(4'b0010, 32'hFFFF_FFFF, 32'h0000_0001, "R3");
      drive(4'b0010, 32'h7FFF_FFFF, 32'h0000_0001, "R8");
      drive(4'b0010, 32'h8000_0000, 32'h8000_0000, "R8");
      // R4 directed
      drive(4'b0110, 32'h0000_0005, 32'h0000_0007, "R4");
      drive(4'b0110, 32'h8000_0000, 32'h0000_0001, "R8");
      drive(4'b0110, 32'h7FFF_FFFF, 32'hFFFF_FFFF, "R8");
      drive(4'b0110, 32'hDEAD_BEEF, 32'hDEAD_BEEF, "R7");
      // R5 directed
      drive(4'b1100, 32'h0000_0000, 32'h0000_0000, "R5");
      drive(4'b1100, 32'hAAAA_AAAA, 32'h5555_5555, "R5");
      // R6 directed including overflowed subtraction
      drive(4'b0111, 32'h7FFF_FFFF, 32'h8000_0000, "R6");
      drive(4'b0111, 32'h8000_0000, 32'h7FFF_FFFF, "R6");
      drive(4'b0111, 32'hFFFF_FFFF, 32'h0000_0000, "R6");
      drive(4'b0111, 32'h0000_0003, 32'h0000_0003, "R6");
      drive(4'b0111, 32'h0000_0002, 32'h0000_0003, "R6");
      // R9 field-driven codes
      drive(4'b1000, 32'h0F0F_0F0F, 32'hFFFF_0000, "R9");
      drive(4'b1101, 32'h0F0F_0F0F, 32'hFFFF_0000, "R9");
      drive(4'b1110, 32'h0000_0010, 32'h0000_0003, "R9");
      drive(4'b0100, 32'hFFFF_FFFF, 32'h1234_5678, "R9");
      drive(4'b1001, 32'h0000_0000, 32'h0000_0000, "R9");
      // random sweep over every listed code
      for (int k = 0; k < 300; k++) begin
         logic [W-1:0] ra, rb;
         rng = next_rng(rng); ra = rng;
         rng = next_rng(rng); rb = rng;
         if (k % 10 == 0) rb = ra;
         drive(4'b0000, ra, rb, "R1");
         drive(4'b0001, ra, rb, "R2");
         drive(4'b0010, ra, rb, "R3");
         drive(4'b0110, ra, rb, "R4");
         drive(4'b1100, ra, rb, "R5");
         drive(4'b0111, ra, rb, "R6");
         drive(4'b1110, ra, rb, "R9");
      end
      while (q.size() > 0) @(negedge clk);
      @(negedge clk);
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end
endmodule